// File: doc/BRIEF.md
# Asynchronous Character Deframer with Break Detection

The block takes a serial line that has already been brought into the clock domain. It arrives as one bit per cycle in which a strobe is high. The block pulls asynchronous characters out of this stream. Each character is a 0 start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one or two stop slots. The data is delivered as a byte together with framing, parity and break flags.

A message counter groups the delivered bytes into messages of a programmed length. A last-byte strobe marks the end of each message. A framing error, a parity error or a received break closes the current message at once, so downstream storage can hand over a short message without waiting for the programmed count.

The receiver accepts stop bits deleted to absorb rate overspeed: a 0 in the final stop slot is taken as the start bit of the next character. A long run of 0 bits is reported as a break. After a break, the receiver stays silent until the line has returned to 1.

Top module: `char_deframer`

## Requirements
- R1: `bit_i` is sampled only in cycles with `bit_en_i` high. Each received character or break produces a one-cycle `byte_vld_o` pulse in the clock cycle after the strobed cycle that delivered its last slot. `byte_vld_o` is never high without a strobe in the previous cycle.
- R2: `cfg_len_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits arrive least significant first, and `byte_o` bits above the selected length read 0.
- R3: `cfg_par_i` selects the parity mode: 0 none, 1 odd, 2 even, 3 stick. In stick mode the parity bit must equal `cfg_stick_i`. When a mode other than none is selected, one parity bit follows the data. A mismatch sets `par_err_o` with the byte.
- R4: `cfg_stop2_i` high selects two stop slots. A 0 in the first of two slots is a framing error (`frm_err_o`), and the receiver then waits for a fresh 0 start bit.
- R5: A 0 in the final stop slot is accepted without error as the start bit of the next character (a deleted stop bit). A deletion in the final slot of the character that immediately follows is reported as a framing error, and that 0 is not taken as a start bit.
- R6: A break is declared when a run of 2M+3 consecutive strobed 0 bits completes. M is the number of data bits plus one if parity is enabled. The break is reported as a `byte_vld_o` pulse with `byte_o` = 0, `brk_o` high, `msg_end_o` high and no framing or parity flag, and it takes precedence over any character result on the same bit. A run one bit shorter produces no break.
- R7: After a break, no character is received until at least one strobed 1 bit has been seen.
- R8: A character with a framing or parity error is still delivered with its flags, and `msg_end_o` is high on that same byte.
- R9: Without errors or breaks, `msg_end_o` is high on exactly every `cfg_msg_len_i`-th byte. The byte count restarts after every message end, including early ones. A length of 0 behaves as 1.
- R10: While `rst_ni` is low, all outputs are 0, and a character partly received before reset has no effect afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Strobe: `bit_i` is valid this cycle |
| bit_i | input | 1 | Serial line bit |
| cfg_len_i | input | 2 | Data length code, 5 + value bits |
| cfg_par_i | input | 2 | Parity mode: 0 none, 1 odd, 2 even, 3 stick |
| cfg_stick_i | input | 1 | Expected parity bit in stick mode |
| cfg_stop2_i | input | 1 | Two stop slots when high |
| cfg_msg_len_i | input | MSG_W | Bytes per message (0 acts as 1) |
| byte_vld_o | output | 1 | One-cycle pulse: result valid |
| byte_o | output | 8 | Received data, 0 for a break |
| frm_err_o | output | 1 | Framing error on this byte |
| par_err_o | output | 1 | Parity error on this byte |
| brk_o | output | 1 | This result is a break marker |
| msg_end_o | output | 1 | This byte closes the message |

## Verification
The bench chains characters with deleted stop bits. A receiver that rejects a single deletion flags a good byte. One that tolerates two in a row misses a framing error. One that does not reuse the 0 as a start bit shifts every later character. Zero runs of exactly 2M+3 and 2M+2 bits are sent with and without parity. An off-by-one threshold or a length M that ignores the parity bit either misses the break or reports one on a valid run of zero bytes. Extra zeros after a break expose a receiver that restarts without a mark. Messages with a parity error midway expose a byte counter that does not restart or does not close early.

// File: rtl/char_deframer_pkg.sv
package char_deframer_pkg;
  localparam int DATA_W     = 8;
  localparam int MIN_DATA_W = 5;
  localparam int LEN_W      = $clog2(DATA_W - MIN_DATA_W + 1);
  localparam int IDX_W      = $clog2(DATA_W);
  localparam int MAX_CHAR_W = DATA_W + 1;
  localparam int MAX_BRK    = 2 * MAX_CHAR_W + 3;
  localparam int RUN_W      = $clog2(MAX_BRK + 1);

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_EVEN  = 2'd2,
    PAR_STICK = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAR,
    ST_STOP_A,
    ST_STOP_F,
    ST_BRK
  } rx_state_e;

  typedef struct packed {
    logic              vld;
    logic [DATA_W-1:0] data;
    logic              frm;
    logic              par;
    logic              brk;
    logic              last;
  } rx_event_t;
endpackage

// File: rtl/cdf_parity_chk.sv
module cdf_parity_chk
  import char_deframer_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        mode_i,
  input  logic              stick_i,
  input  logic              par_bit_i,
  output logic              par_err_o
);
  logic sum;

  // Unused data bits are held at 0, so a full-width reduction is safe.
  assign sum = (^data_i) ^ par_bit_i;

  always_comb begin
    unique case (par_mode_e'(mode_i))
      PAR_ODD:   par_err_o = ~sum;
      PAR_EVEN:  par_err_o = sum;
      PAR_STICK: par_err_o = par_bit_i ^ stick_i;
      default:   par_err_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cdf_break_det.sv
module cdf_break_det
  import char_deframer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  logic             arm_i,
  input  logic [RUN_W-1:0] thr_i,
  output logic             hit_o
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (bit_en_i) begin
      if (bit_i)              run_q <= '0;
      else if (run_q != '1)   run_q <= run_q + 1'b1;
    end
  end

  // Fires on the bit that completes the run.
  assign hit_o = bit_en_i & ~bit_i & arm_i & (run_q == thr_i - 1'b1);
endmodule

// File: rtl/cdf_msg_cnt.sv
module cdf_msg_cnt #(
  parameter int MSG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emit_i,
  input  logic             force_i,
  input  logic [MSG_W-1:0] len_i,
  output logic             last_o
);
  logic [MSG_W-1:0] cnt_q;
  logic [MSG_W:0]   nxt;

  assign nxt    = {1'b0, cnt_q} + 1'b1;
  assign last_o = emit_i & (force_i | (nxt >= {1'b0, len_i}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (emit_i) cnt_q <= last_o ? '0 : nxt[MSG_W-1:0];
  end
endmodule

// File: rtl/char_deframer.sv
module char_deframer
  import char_deframer_pkg::*;
#(
  parameter int MSG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [1:0]        cfg_par_i,
  input  logic              cfg_stick_i,
  input  logic              cfg_stop2_i,
  input  logic [MSG_W-1:0]  cfg_msg_len_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              frm_err_o,
  output logic              par_err_o,
  output logic              brk_o,
  output logic              msg_end_o
);
  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              pbit_q, pbit_d;
  logic              del_q, del_d;
  logic              emit, e_frm, e_brk, chk_par;
  logic              par_bad, brk_hit, last;
  logic              par_en;
  logic [IDX_W-1:0]  last_idx;
  logic [RUN_W-1:0]  char_bits, thr;
  rx_state_e         stop_entry;
  rx_event_t         ev_q;

  assign par_en     = (cfg_par_i != 2'd0);
  assign last_idx   = IDX_W'(MIN_DATA_W - 1) + IDX_W'(cfg_len_i);
  assign char_bits  = RUN_W'(MIN_DATA_W) + RUN_W'(cfg_len_i) + RUN_W'(par_en);
  assign thr        = (char_bits << 1) + RUN_W'(3);
  assign stop_entry = cfg_stop2_i ? ST_STOP_A : ST_STOP_F;

  cdf_parity_chk u_par (
    .data_i    (shreg_q),
    .mode_i    (cfg_par_i),
    .stick_i   (cfg_stick_i),
    .par_bit_i (pbit_q),
    .par_err_o (par_bad)
  );

  cdf_break_det u_brk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .bit_i    (bit_i),
    .arm_i    (state_q != ST_BRK),
    .thr_i    (thr),
    .hit_o    (brk_hit)
  );

  cdf_msg_cnt #(.MSG_W(MSG_W)) u_msg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .emit_i  (emit),
    .force_i (e_frm | e_brk | (chk_par & par_bad)),
    .len_i   (cfg_msg_len_i),
    .last_o  (last)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    shreg_d = shreg_q;
    pbit_d  = pbit_q;
    del_d   = del_q;
    emit    = 1'b0;
    e_frm   = 1'b0;
    e_brk   = 1'b0;
    chk_par = 1'b0;
    if (bit_en_i) begin
      if (brk_hit) begin
        // Break wins over any character result on this bit.
        state_d = ST_BRK;
        emit    = 1'b1;
        e_brk   = 1'b1;
        del_d   = 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (!bit_i) begin
              state_d = ST_DATA;
              idx_d   = '0;
              shreg_d = '0;
            end
          end
          ST_DATA: begin
            shreg_d[idx_q] = bit_i;
            if (idx_q == last_idx) state_d = par_en ? ST_PAR : stop_entry;
            else                   idx_d   = idx_q + 1'b1;
          end
          ST_PAR: begin
            pbit_d  = bit_i;
            state_d = stop_entry;
          end
          ST_STOP_A: begin
            if (bit_i) begin
              state_d = ST_STOP_F;
            end else begin
              emit    = 1'b1;
              chk_par = 1'b1;
              e_frm   = 1'b1;
              del_d   = 1'b0;
              state_d = ST_IDLE;
            end
          end
          ST_STOP_F: begin
            emit    = 1'b1;
            chk_par = 1'b1;
            if (bit_i) begin
              del_d   = 1'b0;
              state_d = ST_IDLE;
            end else if (del_q) begin
              e_frm   = 1'b1;
              del_d   = 1'b0;
              state_d = ST_IDLE;
            end else begin
              // Deleted stop bit: this 0 is the next start bit.
              del_d   = 1'b1;
              state_d = ST_DATA;
              idx_d   = '0;
              shreg_d = '0;
            end
          end
          ST_BRK: begin
            if (bit_i) state_d = ST_IDLE;
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
      pbit_q  <= 1'b0;
      del_q   <= 1'b0;
      ev_q    <= '0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      shreg_q   <= shreg_d;
      pbit_q    <= pbit_d;
      del_q     <= del_d;
      ev_q.vld  <= emit;
      ev_q.data <= e_brk ? '0 : shreg_q;
      ev_q.frm  <= e_frm;
      ev_q.par  <= chk_par & par_bad & ~e_brk;
      ev_q.brk  <= e_brk;
      ev_q.last <= last;
    end
  end

  assign byte_vld_o = ev_q.vld;
  assign byte_o     = ev_q.data;
  assign frm_err_o  = ev_q.frm;
  assign par_err_o  = ev_q.par;
  assign brk_o      = ev_q.brk;
  assign msg_end_o  = ev_q.last;
endmodule

// File: rtl/char_deframer_chk.sv
module char_deframer_chk
  import char_deframer_pkg::*;
#(
  parameter int MSG_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_en_i,
  input logic              bit_i,
  input logic [LEN_W-1:0]  cfg_len_i,
  input logic              byte_vld_o,
  input logic [DATA_W-1:0] byte_o,
  input logic              frm_err_o,
  input logic              par_err_o,
  input logic              brk_o,
  input logic              msg_end_o
);
  AST_VLD_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(bit_en_i)); // R1

  AST_FLAGS_NEED_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> !(frm_err_o || par_err_o || brk_o || msg_end_o)); // R8

  AST_UPPER_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && !brk_o) |-> ((byte_o >> (5 + $past(cfg_len_i))) == '0)); // R2

  AST_ERR_CLOSES_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && (frm_err_o || par_err_o)) |-> msg_end_o); // R8

  AST_BRK_MARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (byte_vld_o && msg_end_o && byte_o == '0 && !frm_err_o && !par_err_o)); // R6

  AST_BRK_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> ($past(bit_en_i) && !$past(bit_i))); // R6
endmodule

bind char_deframer char_deframer_chk #(.MSG_W(MSG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .bit_i      (bit_i),
  .cfg_len_i  (cfg_len_i),
  .byte_vld_o (byte_vld_o),
  .byte_o     (byte_o),
  .frm_err_o  (frm_err_o),
  .par_err_o  (par_err_o),
  .brk_o      (brk_o),
  .msg_end_o  (msg_end_o)
);

// File: tb/sim_char_deframer.sv
`timescale 1ns/1ps
module sim_char_deframer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic       bit_i = 1'b1;
  logic [1:0] cfg_len_i = 2'd3;
  logic [1:0] cfg_par_i = 2'd0;
  logic       cfg_stick_i = 1'b0;
  logic       cfg_stop2_i = 1'b0;
  logic [7:0] cfg_msg_len_i = 8'd255;
  logic       byte_vld_o;
  logic [7:0] byte_o;
  logic       frm_err_o, par_err_o, brk_o, msg_end_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  char_deframer #(.MSG_W(8)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_i(bit_i),
    .cfg_len_i(cfg_len_i), .cfg_par_i(cfg_par_i), .cfg_stick_i(cfg_stick_i),
    .cfg_stop2_i(cfg_stop2_i), .cfg_msg_len_i(cfg_msg_len_i),
    .byte_vld_o(byte_vld_o), .byte_o(byte_o), .frm_err_o(frm_err_o),
    .par_err_o(par_err_o), .brk_o(brk_o), .msg_end_o(msg_end_o)
  );

  // Result log, recorded shortly after each rising edge.
  logic [11:0] ev_log [0:127];
  int ev_n = 0;
  always @(posedge clk_i) begin
    #2;
    if (byte_vld_o && ev_n < 128) begin
      ev_log[ev_n] = {byte_o, par_err_o, frm_err_o, brk_o, msg_end_o};
      ev_n++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] pm;
    logic       stick;
    logic       stop2;
    logic       flip;
    logic [1:0] sm;     // 0 good stops, 1 final slot 0, 2 first of two slots 0
    logic [7:0] data;
    logic [7:0] xb;
    logic       xp;
    logic       xf;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'hA5, 8'hA5, 1'b0, 1'b0}, // R2 8 bits
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h13, 8'h13, 1'b0, 1'b0}, // R2 5 bits
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 8'h55, 8'h55, 1'b0, 1'b0}, // R3 even ok
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 8'h55, 8'h55, 1'b1, 1'b0}, // R3 even bad
    '{2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h3C, 8'h3C, 1'b0, 1'b0}, // R3 odd ok
    '{2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 8'h2A, 8'h2A, 1'b0, 1'b0}, // R3 stick 1
    '{2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 8'h15, 8'h15, 1'b1, 1'b0}, // R3 stick 0 bad
    '{2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 8'hC3, 8'hC3, 1'b0, 1'b0}, // R4 two stops
    '{2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h81, 8'h81, 1'b0, 1'b0}, // R5 deleted
    '{2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h7E, 8'h7E, 1'b0, 1'b0}, // R5 chained
    '{2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h11, 8'h11, 1'b0, 1'b0}, // R5 deleted
    '{2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h22, 8'h22, 1'b0, 1'b1}, // R5 second deletion
    '{2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 2'd2, 8'h5A, 8'h5A, 1'b0, 1'b1}, // R4 first stop 0
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'hF3, 8'h13, 1'b0, 1'b0}, // R2 masked
    '{2'd3, 2'd1, 1'b0, 1'b1, 1'b1, 2'd2, 8'h0F, 8'h0F, 1'b1, 1'b1}  // R8 both errors
  };

  task automatic put_bit(input logic b);
    @(negedge clk_i);
    bit_en_i = 1'b1;
    bit_i    = b;
    @(negedge clk_i);
    bit_en_i = 1'b0;
  endtask

  task automatic put_run(input logic b, input int n);
    for (int k = 0; k < n; k++) put_bit(b);
  endtask

  task automatic send_char(input logic [7:0] data, input logic [1:0] len, input logic [1:0] pm,
                           input logic stick, input logic stop2, input logic flip,
                           input logic [1:0] sm, input bit skip_start);
    logic [7:0] d;
    logic p;
    d = data & ((8'd1 << (5 + len)) - 8'd1);
    if (!skip_start) put_bit(1'b0);
    for (int k = 0; k < 5 + int'(len); k++) put_bit(d[k]);
    if (pm != 2'd0) begin
      p = (pm == 2'd1) ? ~^d : (pm == 2'd2) ? ^d : stick;
      put_bit(p ^ flip);
    end
    if (stop2) begin
      put_bit(sm == 2'd2 ? 1'b0 : 1'b1);
      if (sm == 2'd2) return;
    end
    put_bit(sm == 2'd1 ? 1'b0 : 1'b1);
  endtask

  task automatic check_ev(input int idx, input logic [7:0] b, input logic p, input logic f,
                          input logic k, input logic e, input string req);
    logic [11:0] exp_v;
    exp_v = {b, p, f, k, e};
    checks++;
    if (ev_n <= idx) begin
      failures++;
      $display("FAIL %s: result %0d missing, actual count=%0d expected above %0d", req, idx, ev_n, idx);
    end else if (ev_log[idx] !== exp_v) begin
      failures++;
      $display("FAIL %s: result %0d actual byte=%h p=%b f=%b brk=%b end=%b expected byte=%h p=%b f=%b brk=%b end=%b",
               req, idx, ev_log[idx][11:4], ev_log[idx][3], ev_log[idx][2], ev_log[idx][1], ev_log[idx][0],
               b, p, f, k, e);
    end
  endtask

  task automatic check_cnt(input int exp_n, input string req);
    checks++;
    if (ev_n != exp_n) begin
      failures++;
      $display("FAIL %s: result count actual=%0d expected=%0d", req, ev_n, exp_n);
    end
  endtask

  task automatic set_cfg(input logic [1:0] len, input logic [1:0] pm, input logic stick,
                         input logic stop2, input logic [7:0] ml);
    cfg_len_i = len; cfg_par_i = pm; cfg_stick_i = stick; cfg_stop2_i = stop2; cfg_msg_len_i = ml;
  endtask

  task automatic do_reset();
    bit_en_i = 1'b0;
    bit_i    = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    checks++;
    if ({byte_vld_o, byte_o, frm_err_o, par_err_o, brk_o, msg_end_o} !== 13'd0) begin
      failures++;
      $display("FAIL R10: outputs in reset actual=%h expected=0",
               {byte_vld_o, byte_o, frm_err_o, par_err_o, brk_o, msg_end_o});
    end
    rst_ni = 1'b1;
    put_run(1'b1, 2);
  endtask

  initial begin
    int base;
    bit chain;
    do_reset();

    // Table walk, long messages so only errors close a message.
    chain = 1'b0;
    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i].len, VECS[i].pm, VECS[i].stick, VECS[i].stop2, 8'd255);
      base = ev_n;
      send_char(VECS[i].data, VECS[i].len, VECS[i].pm, VECS[i].stick, VECS[i].stop2,
                VECS[i].flip, VECS[i].sm, chain);
      check_ev(base, VECS[i].xb, VECS[i].xp, VECS[i].xf, 1'b0, VECS[i].xp | VECS[i].xf,
               "R2 R3 R4 R5 R8 vector");
      check_cnt(base + 1, "R1 one result per character");
      chain = (VECS[i].sm == 2'd1) && !VECS[i].xf;
      if (!chain) put_run(1'b1, 2);
    end

    // R10: reset in the middle of a character.
    set_cfg(2'd3, 2'd0, 1'b0, 1'b0, 8'd255);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    do_reset();
    base = ev_n;
    send_char(8'h5A, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    put_run(1'b1, 2);
    check_cnt(base + 1, "R10 partial character discarded");
    check_ev(base, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, "R10 clean restart");

    // R9: message length 3 with even parity, early close on a parity error.
    do_reset();
    set_cfg(2'd3, 2'd2, 1'b0, 1'b0, 8'd3);
    base = ev_n;
    for (int k = 0; k < 8; k++) begin
      send_char(8'h10 + 8'(k), 2'd3, 2'd2, 1'b0, 1'b0, (k == 4), 2'd0, 1'b0);
      put_run(1'b1, 1);
    end
    check_ev(base + 0, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, "R9 byte 1");
    check_ev(base + 1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, "R9 byte 2");
    check_ev(base + 2, 8'h12, 1'b0, 1'b0, 1'b0, 1'b1, "R9 byte 3 ends");
    check_ev(base + 3, 8'h13, 1'b0, 1'b0, 1'b0, 1'b0, "R9 restart");
    check_ev(base + 4, 8'h14, 1'b1, 1'b0, 1'b0, 1'b1, "R8 parity error closes early");
    check_ev(base + 5, 8'h15, 1'b0, 1'b0, 1'b0, 1'b0, "R9 restart after early end");
    check_ev(base + 6, 8'h16, 1'b0, 1'b0, 1'b0, 1'b0, "R9 byte 2 of new message");
    check_ev(base + 7, 8'h17, 1'b0, 1'b0, 1'b0, 1'b1, "R9 byte 3 of new message");

    // R9: a length of 0 acts as 1.
    set_cfg(2'd3, 2'd0, 1'b0, 1'b0, 8'd0);
    base = ev_n;
    send_char(8'h21, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    send_char(8'h22, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    put_run(1'b1, 2);
    check_ev(base, 8'h21, 1'b0, 1'b0, 1'b0, 1'b1, "R9 zero length");
    check_ev(base + 1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, "R9 zero length again");

    // R6: 8 bits, no parity, M=8, threshold 19. A run of 18 zeros is two zero bytes.
    do_reset();
    set_cfg(2'd3, 2'd0, 1'b0, 1'b0, 8'd255);
    base = ev_n;
    put_run(1'b0, 18);
    put_run(1'b1, 2);
    check_cnt(base + 2, "R6 run of 2M+2 is no break");
    check_ev(base, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R5 zero byte with deleted stop");
    check_ev(base + 1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R6 second zero byte");

    base = ev_n;
    put_run(1'b0, 19);
    check_ev(base, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R6 zero byte before break");
    check_ev(base + 1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R6 break at 2M+3");
    put_run(1'b0, 12);
    check_cnt(base + 2, "R7 zeros after break ignored");
    put_bit(1'b1);
    check_cnt(base + 2, "R7 mark after break is silent");
    send_char(8'hA5, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    put_run(1'b1, 2);
    check_ev(base + 2, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, "R7 reception resumes after mark");

    // R6: 5 bits with odd parity, M=6, threshold 15.
    set_cfg(2'd0, 2'd1, 1'b0, 1'b0, 8'd255);
    base = ev_n;
    put_run(1'b0, 15);
    put_run(1'b1, 2);
    check_cnt(base + 2, "R6 parity run result count");
    check_ev(base, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R3 zero byte odd parity error");
    check_ev(base + 1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R6 break counts parity bit");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule